// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a 10-bit successive-approximation converter. It drives a trial code to an external DAC and reads back one comparator bit, which is high when the sampled input is at or above the DAC level. Bits are settled from the most significant down, one per divided converter clock. The finished code is placed on the result output. Code 0 stands for ground, and the all-ones code stands for the reference voltage less one LSB.

A conversion can start in two ways. Software can pulse the start input, or the rising edge of one of eight trigger lines can start it when auto-triggering is on. The converter clock is divided from the system clock by a 3-bit prescaler code. The channel and reference selections are copied to their outputs only while the block is enabled and idle. A completion flag is set when a conversion finishes, and combined with an interrupt enable it drives a registered interrupt request. Clearing the enable input stops all activity at once.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `busy_o`, `flag_o`, `irq_o`, `result_o` and `dac_code_o` are all zero.
- R2: With the comparator reporting (input >= DAC code), the result equals the input code. Bit 9 is resolved first. A trial bit is kept when `cmp_i` is 1 and dropped when it is 0.
- R3: Prescaler codes 0..7 give divisions d = 2, 2, 4, 8, 16, 32, 64, 128. A conversion keeps `busy_o` high for between 9·d+1 and 10·d clock cycles.
- R4: `busy_o` rises on the edge that accepts a start and falls on the edge that stores the result. A start pulse while busy has no effect.
- R5: While `en_i` is 0, start pulses and triggers are ignored. Dropping `en_i` during a conversion clears `busy_o` and sets no flag.
- R6: `chan_o` and `ref_o` take the value of `chan_sel_i` and `ref_sel_i` one edge later, but only while `en_i` is 1 and no conversion is running. Otherwise they hold.
- R7: `flag_o` is set on the edge that ends a conversion. A one-cycle pulse on `flag_clr_i` clears it.
- R8: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` was 1 at the preceding edge.
- R9: With `auto_en_i` = 1, a 0→1 change on `trig_src_i[trig_sel_i]` starts a conversion two edges later. Edges on unselected lines, and all edges while `auto_en_i` = 0, start nothing.
- R10: A trigger edge arriving during a conversion is dropped. No second conversion follows.
- R11: On the edge that accepts a start, `dac_code_o` becomes 10'h200, the midscale trial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable |
| start_wr_i | input | 1 | Software start pulse |
| auto_en_i | input | 1 | Auto-trigger enable |
| trig_sel_i | input | 3 | Index of the trigger line to watch |
| trig_src_i | input | 8 | Trigger source lines |
| psc_sel_i | input | 3 | Converter clock division code |
| chan_sel_i | input | 5 | Requested input channel |
| ref_sel_i | input | 2 | Requested reference |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clear pulse for the completion flag |
| cmp_i | input | 1 | Comparator: 1 when input >= DAC code |
| dac_code_o | output | 10 | Trial code for the DAC |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | 10 | Last completed result |
| flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Interrupt request |
| chan_o | output | 5 | Applied channel selection |
| ref_o | output | 2 | Applied reference selection |

## Verification
Several rules are checked on every cycle:
- Busy is never high unless the enable was present at the prior edge.
- The flag can rise only where busy falls.
- The interrupt request follows the flag gated by the previous interrupt enable.
- The channel and reference hold while busy or disabled.
- Every conversion opens at the midscale trial.

Other behaviour needs the directed scenarios:
- Result accuracy for chosen input codes, including both end codes, is confirmed only there.
- So is conversion length under each prescaler division.
- So are trigger selection by index, and dropped starts and triggers during a conversion, since these depend on stimulus history.

// File: rtl/sar_pkg.sv
package sar_pkg;
  function automatic int unsigned div_exp(input int unsigned code);
    return (code == 0) ? 1 : code;
  endfunction
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] psc_sel,
  output logic             tick
);
  import sar_pkg::*;
  localparam int CNT_W = (1 << PSC_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(div_exp(int'(psc_sel)))) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && ((cnt_q & mask) == mask);
endmodule

// File: rtl/sar_trig_edge.sv
module sar_trig_edge #(
  parameter int TRIG_N = 8,
  localparam int TSEL_W = $clog2(TRIG_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TRIG_N-1:0] src,
  input  logic [TSEL_W-1:0] sel,
  output logic              rise
);
  logic pick_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pick_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      pick_q <= src[sel];
      prev_q <= pick_q;
    end
  end

  assign rise = pick_q & ~prev_q;
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 10,
  localparam int IDX_W = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             tick,
  input  logic             cmp,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] bit_m, kept, nxt;

  always_comb begin
    bit_m = '0;
    bit_m[idx_q] = 1'b1;
    kept  = cmp ? trial : (trial & ~bit_m);
    nxt   = kept | (bit_m >> 1);
  end

  assign done = en && busy && tick && (idx_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      trial  <= '0;
      result <= '0;
    end else if (!en) begin
      busy  <= 1'b0;
      trial <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      idx_q <= IDX_W'(RES_W - 1);
      trial <= RES_W'(1) << (RES_W - 1);
    end else if (busy && tick) begin
      if (idx_q == '0) begin
        busy   <= 1'b0;
        result <= kept;
        trial  <= kept;
      end else begin
        idx_q <= idx_q - 1'b1;
        trial <= nxt;
      end
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int RES_W  = 10,
  parameter int CHAN_W = 5,
  parameter int REF_W  = 2,
  parameter int PSC_W  = 3,
  parameter int TRIG_N = 8,
  localparam int TSEL_W = $clog2(TRIG_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              start_wr_i,
  input  logic              auto_en_i,
  input  logic [TSEL_W-1:0] trig_sel_i,
  input  logic [TRIG_N-1:0] trig_src_i,
  input  logic [PSC_W-1:0]  psc_sel_i,
  input  logic [CHAN_W-1:0] chan_sel_i,
  input  logic [REF_W-1:0]  ref_sel_i,
  input  logic              irq_en_i,
  input  logic              flag_clr_i,
  input  logic              cmp_i,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              busy_o,
  output logic [RES_W-1:0]  result_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [REF_W-1:0]  ref_o
);
  logic tick, trig_rise, start_req, done, flag_nxt;

  sar_clk_div #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst(rst), .run(en_i), .psc_sel(psc_sel_i), .tick(tick)
  );

  sar_trig_edge #(.TRIG_N(TRIG_N)) u_trig (
    .clk(clk), .rst(rst), .src(trig_src_i), .sel(trig_sel_i), .rise(trig_rise)
  );

  assign start_req = en_i && !busy_o && (start_wr_i || (auto_en_i && trig_rise));

  sar_approx #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .en(en_i), .start(start_req), .tick(tick),
    .cmp(cmp_i), .busy(busy_o), .done(done), .trial(dac_code_o),
    .result(result_o)
  );

  always_comb begin
    if (done)            flag_nxt = 1'b1;
    else if (flag_clr_i) flag_nxt = 1'b0;
    else                 flag_nxt = flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
      chan_o <= '0;
      ref_o  <= '0;
    end else begin
      flag_o <= flag_nxt;
      irq_o  <= flag_nxt & irq_en_i;
      if (en_i && !busy_o) begin
        chan_o <= chan_sel_i;
        ref_o  <= ref_sel_i;
      end
    end
  end
endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int RES_W  = 10,
  parameter int CHAN_W = 5,
  parameter int REF_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              irq_en_i,
  input logic [RES_W-1:0]  dac_code_o,
  input logic              busy_o,
  input logic              flag_o,
  input logic              irq_o,
  input logic [CHAN_W-1:0] chan_o,
  input logic [REF_W-1:0]  ref_o
);
  a_r5_busy_needs_en: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> $past(en_i));

  a_r7_flag_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $fell(busy_o));

  a_r8_irq_implies_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (flag_o && $past(irq_en_i)) |-> irq_o);

  a_r6_sel_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_o) || !$past(en_i)) |-> ($stable(chan_o) && $stable(ref_o)));

  a_r11_midscale_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (dac_code_o == (RES_W'(1) << (RES_W - 1))));
endmodule

bind sar_conv_ctrl sar_conv_chk #(.RES_W(RES_W), .CHAN_W(CHAN_W), .REF_W(REF_W)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .irq_en_i(irq_en_i),
  .dac_code_o(dac_code_o), .busy_o(busy_o), .flag_o(flag_o), .irq_o(irq_o),
  .chan_o(chan_o), .ref_o(ref_o)
);

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic en_i = 0, start_wr_i = 0, auto_en_i = 0, irq_en_i = 0, flag_clr_i = 0;
  logic [2:0] trig_sel_i = 0, psc_sel_i = 0;
  logic [7:0] trig_src_i = 0;
  logic [4:0] chan_sel_i = 0;
  logic [1:0] ref_sel_i = 0;
  logic [9:0] vin = 0;
  logic cmp_i;
  logic [9:0] dac_code_o, result_o;
  logic busy_o, flag_o, irq_o;
  logic [4:0] chan_o;
  logic [1:0] ref_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmp_i = (vin >= dac_code_o);

  sar_conv_ctrl u0 (
    .clk(clk), .rst(rst), .en_i(en_i), .start_wr_i(start_wr_i),
    .auto_en_i(auto_en_i), .trig_sel_i(trig_sel_i), .trig_src_i(trig_src_i),
    .psc_sel_i(psc_sel_i), .chan_sel_i(chan_sel_i), .ref_sel_i(ref_sel_i),
    .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .busy_o(busy_o), .result_o(result_o),
    .flag_o(flag_o), .irq_o(irq_o), .chan_o(chan_o), .ref_o(ref_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr_i = 1;
    @(negedge clk) flag_clr_i = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_wr_i = 1;
    @(negedge clk) start_wr_i = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy_o == 0 && flag_o == 0 && irq_o == 0, "R1 ctrl", {busy_o, flag_o, irq_o}, 0);
    chk(result_o == 0 && dac_code_o == 0, "R1 data", result_o + dac_code_o, 0);
  endtask

  task automatic t_convert(input int code, input int psc);
    int d, n;
    d = (psc == 0) ? 2 : (1 << psc);
    psc_sel_i = 3'(psc);
    vin = 10'(code);
    clear_flag();
    pulse_start();
    chk(busy_o == 1, "R4 busy set", busy_o, 1);
    chk(dac_code_o == 10'h200, "R11 midscale", dac_code_o, 10'h200);
    wait_idle(n);
    chk(result_o == 10'(code), "R2 result", result_o, code);
    chk(n >= 9*d+1 && n <= 10*d, "R3 duration", n, 10*d);
    chk(flag_o == 1, "R7 flag set", flag_o, 1);
  endtask

  task automatic t_start_busy();
    int n;
    psc_sel_i = 3'd4;
    vin = 10'd100;
    clear_flag();
    pulse_start();
    repeat (30) @(negedge clk);
    vin = 10'd900;
    pulse_start();
    wait_idle(n);
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R4 no restart", busy_o, 0);
    chk(n + 32 <= 160, "R4 length", n + 32, 160);
  endtask

  task automatic t_disabled();
    clear_flag();
    en_i = 0;
    pulse_start();
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R5 start ignored", busy_o, 0);
    @(negedge clk) en_i = 1;
    psc_sel_i = 3'd5;
    pulse_start();
    repeat (20) @(negedge clk);
    en_i = 0;
    @(negedge clk);
    chk(busy_o == 0, "R5 abort busy", busy_o, 0);
    repeat (400) @(negedge clk);
    chk(flag_o == 0, "R5 abort no flag", flag_o, 0);
    en_i = 1;
  endtask

  task automatic t_select();
    en_i = 0;
    chan_sel_i = 5'd19;
    ref_sel_i = 2'd3;
    repeat (3) @(negedge clk);
    chk(chan_o == 0 && ref_o == 0, "R6 held disabled", chan_o, 0);
    en_i = 1;
    @(negedge clk);
    chk(chan_o == 19 && ref_o == 3, "R6 applied", chan_o, 19);
    psc_sel_i = 3'd3;
    pulse_start();
    chan_sel_i = 5'd7;
    repeat (5) @(negedge clk);
    chk(chan_o == 19, "R6 held busy", chan_o, 19);
    begin int n; wait_idle(n); end
    @(negedge clk);
    chk(chan_o == 7, "R6 applied idle", chan_o, 7);
  endtask

  task automatic t_irq();
    t_convert(555, 1);
    irq_en_i = 0;
    @(negedge clk);
    chk(irq_o == 0, "R8 masked", irq_o, 0);
    irq_en_i = 1;
    @(negedge clk);
    chk(irq_o == 1, "R8 raised", irq_o, 1);
    clear_flag();
    chk(flag_o == 0 && irq_o == 0, "R7 cleared", {flag_o, irq_o}, 0);
    irq_en_i = 0;
  endtask

  task automatic t_trigger();
    int n;
    psc_sel_i = 3'd1;
    trig_sel_i = 3'd5;
    vin = 10'd321;
    clear_flag();
    auto_en_i = 0;
    @(negedge clk) trig_src_i[5] = 1;
    repeat (4) @(negedge clk);
    chk(busy_o == 0, "R9 auto off", busy_o, 0);
    trig_src_i = 0;
    auto_en_i = 1;
    @(negedge clk) trig_src_i[2] = 1;
    repeat (4) @(negedge clk);
    chk(busy_o == 0, "R9 other line", busy_o, 0);
    trig_src_i = 0;
    repeat (2) @(negedge clk);
    trig_src_i[5] = 1;
    @(negedge clk);
    chk(busy_o == 0, "R9 latency one", busy_o, 0);
    @(negedge clk);
    chk(busy_o == 1, "R9 started", busy_o, 1);
    wait_idle(n);
    chk(result_o == 10'd321, "R9 result", result_o, 321);
    trig_src_i = 0;
  endtask

  task automatic t_trig_busy();
    int n;
    psc_sel_i = 3'd4;
    trig_sel_i = 3'd6;
    vin = 10'd77;
    clear_flag();
    pulse_start();
    repeat (40) @(negedge clk);
    trig_src_i[6] = 1;
    wait_idle(n);
    repeat (6) @(negedge clk);
    chk(busy_o == 0, "R10 trigger dropped", busy_o, 0);
    chk(result_o == 10'd77, "R10 result", result_o, 77);
    trig_src_i = 0;
    auto_en_i = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    en_i = 1;
    t_convert(0, 0);
    t_convert(1023, 1);
    t_convert(512, 2);
    t_convert(341, 3);
    t_convert(682, 4);
    t_convert(1, 5);
    t_convert(1022, 6);
    t_convert(600, 7);
    t_start_busy();
    t_disabled();
    t_select();
    t_irq();
    t_trigger();
    t_trig_busy();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule